// File: doc/BRIEF.md
# Floating-Point Result NaN and Denormal Fixup

This block is the clean-up stage placed after a floating-point arithmetic core. It sees the core's raw result together with the one or two source operands, in single or double precision, plus two mode bits: flush-to-zero and default-NaN. It returns the result the architecture requires. When the raw result is a NaN, the block picks which NaN to return and makes sure it is quiet. When flush-to-zero is on, it turns a subnormal result into a zero that keeps the sign of the result, and raises underflow.

The same stage also presents flushed copies of the source operands for the core. Under flush-to-zero, a subnormal operand becomes positive zero and an input-denormal indication is raised. Exception flags and the input-denormal bit are cumulative: they gather the core's own flags and this stage's underflow, and they clear only on reset. All outputs are registered, one cycle after the accepted input. In single precision only the low 32 bits of every data port carry meaning.

Top module: `fp_result_fixup`

## Requirements
- R1: An input accepted with `in_valid` high gives `out_valid` high on the next cycle, with all data and flag outputs updated in that same cycle. With `is_double` low, only bits [31:0] of each data input are used and bits [63:32] of every data output are zero.
- R2: If the raw result is a NaN and either `dnan_en` is high or no considered operand is a NaN, the output is the default quiet NaN: 0x7FC00000 in single precision, 0x7FF8000000000000 in double.
- R3: With `two_ops` high and default-NaN off, a NaN result is taken in this priority: signalling `op_a`, signalling `op_b`, quiet `op_a`, quiet `op_b`.
- R4: A NaN has an all-ones exponent and a non-zero fraction. It is signalling when the top fraction bit (bit 22 single, bit 51 double) is clear. A propagated signalling NaN is returned with the default-NaN pattern OR-ed into its bits, which keeps its sign and payload.
- R5: With `two_ops` low, `op_b` has no effect on the result, on the flags or on `flush_b`. A NaN result becomes `op_a` quietened, or the default NaN when `op_a` is not a NaN or `dnan_en` is high.
- R6: With `ftz_en` high, a subnormal raw result (all-zero exponent, non-zero fraction) becomes a zero that keeps its sign bit, and underflow (`exc_flags[3]`) is set. With `ftz_en` low, a subnormal result passes through unchanged and underflow is not set by the stage.
- R7: With `ftz_en` high, a subnormal `op_a`, or a subnormal `op_b` when `two_ops` is high, is presented on its flush output as positive zero and sets `in_denorm`. Otherwise, each flush output equals its operand.
- R8: `exc_flags` bit positions are [0] invalid, [1] divide-by-zero, [2] overflow, [3] underflow, [4] inexact. On each accepted input, `core_flags` and the stage's underflow are OR-ed into the flags. The flags and `in_denorm` never clear except on reset.
- R9: While `rst` is high, and after it is released, all outputs are zero until the first accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the inputs this cycle |
| is_double | input | 1 | 1 = 64-bit format, 0 = 32-bit format in the low bits |
| two_ops | input | 1 | Operation uses both sources |
| ftz_en | input | 1 | Flush-to-zero mode |
| dnan_en | input | 1 | Default-NaN mode |
| op_a | input | 64 | First source operand |
| op_b | input | 64 | Second source operand |
| raw_res | input | 64 | Unfixed result from the arithmetic core |
| core_flags | input | 5 | Exception flags raised by the core for this operation |
| out_valid | output | 1 | Registered outputs hold a new result |
| fixed_res | output | 64 | Corrected result |
| flush_a | output | 64 | First operand after input flushing |
| flush_b | output | 64 | Second operand after input flushing |
| exc_flags | output | 5 | Cumulative exception flags |
| in_denorm | output | 1 | Cumulative input-denormal indication |

## Verification
The scoreboard targets the NaN ordering cases where a signalling NaN in `op_b` must beat a quiet NaN in `op_a`. A design that checked NaN-ness before signalling-ness would return `op_a` there. It also drives a signalling NaN in a one-operand operation and a NaN in an ignored `op_b`. If the design leaked the second operand, it would quieten the wrong value or miss the default NaN. Flush cases check the asymmetry between a negative subnormal result, which must keep its sign, and a negative subnormal operand, which must become positive zero. They also check that flush-to-zero off leaves both untouched. Single-precision vectors carry junk in the upper half, so a design that classified or forwarded those bits would produce wrong NaN decisions or non-zero upper outputs.

// File: rtl/fpfix_pkg.sv
package fpfix_pkg;

  // classification of one value in the selected format
  typedef struct packed {
    logic nan;
    logic sub;
  } fp_cls_t;

  // exception flag positions
  localparam int unsigned FLG_INV = 0;
  localparam int unsigned FLG_DZ  = 1;
  localparam int unsigned FLG_OF  = 2;
  localparam int unsigned FLG_UF  = 3;
  localparam int unsigned FLG_IX  = 4;

endpackage

// File: rtl/fpfix_classify.sv
module fpfix_classify #(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52
) (
  input  logic                 is_double,
  input  logic [DE+DF:0]       val,
  output fpfix_pkg::fp_cls_t   cls,
  output logic [DE+DF:0]       view
);
  localparam int W = 1 + DE + DF;

  logic [1:0]   nan_f;
  logic [1:0]   sub_f;
  logic [W-1:0] view_f [2];

  // one decoder per format; the format select picks afterwards
  for (genvar g = 0; g < 2; g++) begin : g_fmt
    localparam int E = (g == 0) ? SE : DE;
    localparam int F = (g == 0) ? SF : DF;
    localparam int N = 1 + E + F;

    logic [N-1:0] v;
    logic         exp_ones;
    logic         exp_zero;
    logic         frac_nz;

    assign v         = val[N-1:0];
    assign exp_ones  = &v[N-2:F];
    assign exp_zero  = ~|v[N-2:F];
    assign frac_nz   = |v[F-1:0];
    assign nan_f[g]  = exp_ones & frac_nz;
    assign sub_f[g]  = exp_zero & frac_nz;
    assign view_f[g] = W'(v);
  end

  always_comb begin
    cls.nan = is_double ? nan_f[1] : nan_f[0];
    cls.sub = is_double ? sub_f[1] : sub_f[0];
    view    = is_double ? view_f[1] : view_f[0];
  end

endmodule

// File: rtl/fpfix_nan_pick.sv
module fpfix_nan_pick #(
  parameter int SE = 8,
  parameter int SF = 23,
  parameter int DE = 11,
  parameter int DF = 52
) (
  input  logic           is_double,
  input  logic           two_ops,
  input  logic           dnan_en,
  input  logic           a_nan,
  input  logic           b_nan,
  input  logic [DE+DF:0] view_a,
  input  logic [DE+DF:0] view_b,
  output logic [DE+DF:0] nan_val
);
  localparam int W  = 1 + DE + DF;
  localparam int SN = 1 + SE + SF;
  localparam logic [W-1:0] S_QNAN = W'({1'b0, {SE{1'b1}}, 1'b1, {(SF-1){1'b0}}});
  localparam logic [W-1:0] D_QNAN = {1'b0, {DE{1'b1}}, 1'b1, {(DF-1){1'b0}}};

  logic [W-1:0] qpat;
  logic         a_quiet_bit;
  logic         b_quiet_bit;
  logic         a_snan;
  logic         b_snan;
  logic         b_live;

  assign qpat        = is_double ? D_QNAN : S_QNAN;
  assign a_quiet_bit = is_double ? view_a[DF-1] : view_a[SF-1];
  assign b_quiet_bit = is_double ? view_b[DF-1] : view_b[SF-1];
  assign b_live      = two_ops & b_nan;
  assign a_snan      = a_nan & ~a_quiet_bit;
  assign b_snan      = b_live & ~b_quiet_bit;

  always_comb begin
    if (dnan_en || !(a_nan || b_live))
      nan_val = qpat;
    else if (a_snan)
      nan_val = view_a | qpat;
    else if (b_snan)
      nan_val = view_b | qpat;
    else if (a_nan)
      nan_val = view_a;
    else
      nan_val = view_b;
  end

  // a chosen NaN never leaves the single-precision field
  always_comb begin
    if (!is_double) begin
      a_p_single_width_r1: assert (nan_val[W-1:SN] == '0);
    end
  end

endmodule

// File: rtl/fpfix_flag_acc.sv
module fpfix_flag_acc #(
  parameter int NFLAG  = 5,
  parameter int UF_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [NFLAG-1:0] core_flags,
  input  logic             uf_hit,
  input  logic             idn_hit,
  output logic [NFLAG-1:0] sticky,
  output logic             idn
);
  logic [NFLAG-1:0] uf_mask;

  assign uf_mask = NFLAG'(uf_hit) << UF_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky <= '0;
      idn    <= 1'b0;
    end else if (upd) begin
      sticky <= sticky | core_flags | uf_mask;
      idn    <= idn | idn_hit;
    end
  end

  p_flags_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (sticky & $past(sticky)) == $past(sticky));

  p_idn_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(idn) |-> idn);

  p_core_merge_r8: assert property (@(posedge clk) disable iff (rst)
    upd |=> ((sticky & $past(core_flags)) == $past(core_flags)));

endmodule

// File: rtl/fp_result_fixup.sv
module fp_result_fixup #(
  parameter int SE    = 8,
  parameter int SF    = 23,
  parameter int DE    = 11,
  parameter int DF    = 52,
  parameter int NFLAG = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  is_double,
  input  logic                  two_ops,
  input  logic                  ftz_en,
  input  logic                  dnan_en,
  input  logic [DE+DF:0]        op_a,
  input  logic [DE+DF:0]        op_b,
  input  logic [DE+DF:0]        raw_res,
  input  logic [NFLAG-1:0]      core_flags,
  output logic                  out_valid,
  output logic [DE+DF:0]        fixed_res,
  output logic [DE+DF:0]        flush_a,
  output logic [DE+DF:0]        flush_b,
  output logic [NFLAG-1:0]      exc_flags,
  output logic                  in_denorm
);
  import fpfix_pkg::*;

  localparam int W  = 1 + DE + DF;
  localparam int SN = 1 + SE + SF;

  fp_cls_t      cls_a, cls_b, cls_r, cls_o;
  logic [W-1:0] view_a, view_b, view_r, view_o;
  logic [W-1:0] nan_val;
  logic [W-1:0] szero_r;
  logic [W-1:0] res_d, fa_d, fb_d;
  logic         uf_hit, idn_hit;
  logic         dbl_q, ftz_q;

  fpfix_classify #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_cls_a (
    .is_double(is_double), .val(op_a), .cls(cls_a), .view(view_a));
  fpfix_classify #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_cls_b (
    .is_double(is_double), .val(op_b), .cls(cls_b), .view(view_b));
  fpfix_classify #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_cls_r (
    .is_double(is_double), .val(raw_res), .cls(cls_r), .view(view_r));

  fpfix_nan_pick #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_pick (
    .is_double(is_double),
    .two_ops  (two_ops),
    .dnan_en  (dnan_en),
    .a_nan    (cls_a.nan),
    .b_nan    (cls_b.nan),
    .view_a   (view_a),
    .view_b   (view_b),
    .nan_val  (nan_val)
  );

  // zero carrying the sign of the raw result in the active format
  assign szero_r = is_double ? {view_r[W-1], {(W-1){1'b0}}}
                             : W'({view_r[SN-1], {(SN-1){1'b0}}});

  assign uf_hit  = ftz_en & cls_r.sub;
  assign idn_hit = ftz_en & (cls_a.sub | (two_ops & cls_b.sub));

  always_comb begin
    if (cls_r.nan)
      res_d = nan_val;
    else if (uf_hit)
      res_d = szero_r;
    else
      res_d = view_r;
    fa_d = (ftz_en && cls_a.sub) ? '0 : view_a;
    fb_d = (ftz_en && two_ops && cls_b.sub) ? '0 : view_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      fixed_res <= '0;
      flush_a   <= '0;
      flush_b   <= '0;
      dbl_q     <= 1'b0;
      ftz_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fixed_res <= res_d;
        flush_a   <= fa_d;
        flush_b   <= fb_d;
        dbl_q     <= is_double;
        ftz_q     <= ftz_en;
      end
    end
  end

  fpfix_flag_acc #(.NFLAG(NFLAG), .UF_BIT(FLG_UF)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .upd       (in_valid),
    .core_flags(core_flags),
    .uf_hit    (uf_hit),
    .idn_hit   (idn_hit),
    .sticky    (exc_flags),
    .idn       (in_denorm)
  );

  // re-classify the registered result for the output checks
  fpfix_classify #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_cls_o (
    .is_double(dbl_q), .val(fixed_res), .cls(cls_o), .view(view_o));

  p_single_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !dbl_q) |-> (view_o == fixed_res));

  p_out_nan_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cls_o.nan) |-> (dbl_q ? fixed_res[DF-1] : fixed_res[SF-1]));

  p_out_no_sub_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ftz_q) |-> !cls_o.sub);

  p_uf_raised_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ftz_en && cls_r.sub) |=> exc_flags[FLG_UF]);

  p_in_flush_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ftz_en && cls_a.sub) |=> (in_denorm && flush_a == '0));

endmodule

// File: tb/tb_fp_result_fixup.sv
`timescale 1ns/1ps
module tb_fp_result_fixup;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, is_double, two_ops, ftz_en, dnan_en;
  logic [63:0] op_a, op_b, raw_res;
  logic [4:0]  core_flags;
  logic        out_valid;
  logic [63:0] fixed_res, flush_a, flush_b;
  logic [4:0]  exc_flags;
  logic        in_denorm;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  fp_result_fixup dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .is_double(is_double),
    .two_ops(two_ops), .ftz_en(ftz_en), .dnan_en(dnan_en),
    .op_a(op_a), .op_b(op_b), .raw_res(raw_res), .core_flags(core_flags),
    .out_valid(out_valid), .fixed_res(fixed_res), .flush_a(flush_a),
    .flush_b(flush_b), .exc_flags(exc_flags), .in_denorm(in_denorm)
  );

  typedef struct {
    logic [63:0] res;
    logic [63:0] fa;
    logic [63:0] fb;
    logic [4:0]  flg;
    logic        idn;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  logic [4:0] m_flg = '0;
  logic       m_idn = 1'b0;

  function automatic logic [63:0] lo(input logic [63:0] v, input bit d);
    return d ? v : {32'h0, v[31:0]};
  endfunction
  function automatic bit is_nan(input logic [63:0] v, input bit d);
    return d ? (v[62:52] == 11'h7FF && v[51:0] != 0) : (v[30:23] == 8'hFF && v[22:0] != 0);
  endfunction
  function automatic bit is_sub(input logic [63:0] v, input bit d);
    return d ? (v[62:52] == 0 && v[51:0] != 0) : (v[30:23] == 0 && v[22:0] != 0);
  endfunction
  function automatic bit is_snan(input logic [63:0] v, input bit d);
    return is_nan(v, d) && !(d ? v[51] : v[22]);
  endfunction
  function automatic logic [63:0] qp(input bit d);
    return d ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000;
  endfunction

  task automatic chk(input string tag, input string fld, input logic [63:0] got, input logic [63:0] expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, fld, got, expv);
    end
  endtask

  // driver: compute expectation, queue it, present inputs for one cycle
  task automatic send(input bit d, input bit two, input bit ftz, input bit dn,
                      input logic [63:0] a, input logic [63:0] b, input logic [63:0] r,
                      input logic [4:0] cf, input string tag);
    exp_t e;
    logic [63:0] la, lb, lr;
    la = lo(a, d); lb = lo(b, d); lr = lo(r, d);
    if (is_nan(lr, d)) begin
      if (dn || !(is_nan(la, d) || (two && is_nan(lb, d)))) e.res = qp(d);
      else if (is_snan(la, d))                              e.res = la | qp(d);
      else if (two && is_snan(lb, d))                       e.res = lb | qp(d);
      else if (is_nan(la, d))                               e.res = la;
      else                                                  e.res = lb;
    end else if (ftz && is_sub(lr, d)) begin
      e.res = d ? {lr[63], 63'h0} : {32'h0, lr[31], 31'h0};
      m_flg[3] = 1'b1;
    end else begin
      e.res = lr;
    end
    e.fa = (ftz && is_sub(la, d)) ? 64'h0 : la;
    e.fb = (ftz && two && is_sub(lb, d)) ? 64'h0 : lb;
    if (ftz && (is_sub(la, d) || (two && is_sub(lb, d)))) m_idn = 1'b1;
    m_flg = m_flg | cf;
    e.flg = m_flg;
    e.idn = m_idn;
    e.tag = tag;
    @(negedge clk);
    exp_q.push_back(e);
    in_valid = 1'b1; is_double = d; two_ops = two; ftz_en = ftz; dnan_en = dn;
    op_a = a; op_b = b; raw_res = r; core_flags = cf;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = op_a; raw_res = op_a; core_flags = 5'h1F;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor: compare every produced result against the queue
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk("R1 unexpected out_valid", "valid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "res", fixed_res, e.res);
        chk(e.tag, "flush_a", flush_a, e.fa);
        chk(e.tag, "flush_b", flush_b, e.fb);
        chk(e.tag, "flags", {59'h0, exc_flags}, {59'h0, e.flg});
        chk(e.tag, "in_denorm", {63'h0, in_denorm}, {63'h0, e.idn});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; is_double = 1'b0; two_ops = 1'b0;
    ftz_en = 1'b0; dnan_en = 1'b0; op_a = '0; op_b = '0; raw_res = '0; core_flags = '0;
    repeat (4) @(negedge clk);
    chk("R9 reset", "valid", {63'h0, out_valid}, 64'h0);
    chk("R9 reset", "res", fixed_res, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 after reset", "flags", {58'h0, in_denorm, exc_flags}, 64'h0);
    chk("R9 after reset", "flush_a", flush_a, 64'h0);

    // R1 pass-through, single with junk upper halves
    send(0, 1, 0, 0, 64'hAAAA_5555_3F80_0000, 64'h1234_0000_4000_0000, 64'hDEAD_BEEF_4040_0000, 5'h0, "R1 single pass");
    send(1, 1, 0, 0, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'h4008_0000_0000_0000, 5'h0, "R1 double pass");
    // R5 / R7: one-op, subnormal op_b ignored, no in_denorm
    send(0, 0, 1, 0, 64'h3F80_0000, 64'h0000_0001, 64'h3F80_0000, 5'h0, "R7 R5 op_b subnormal ignored");
    send(0, 0, 0, 0, 64'h3F80_0000, 64'h7F80_0001, 64'h7FC0_0000, 5'h0, "R5 sNaN op_b ignored");
    send(0, 0, 0, 0, 64'hFFFF_FFFF_7F80_0009, 64'h7FC0_0004, 64'h7FC0_0000, 5'h0, "R5 R4 one-op sNaN quietened");
    send(0, 0, 0, 0, 64'h7FC0_0077, 64'h7F80_0001, 64'h7FC0_0000, 5'h0, "R5 one-op qNaN kept");
    idle(3);
    // R3 priority, R4 quieting
    send(0, 1, 0, 0, 64'h7FC0_0010, 64'h7F80_0020, 64'h7FC0_0000, 5'h0, "R3 sNaN b beats qNaN a");
    send(0, 1, 0, 0, 64'hFF80_0005, 64'h7F80_0007, 64'h7FC0_0000, 5'h0, "R3 R4 sNaN a first");
    send(0, 1, 0, 0, 64'h7FC0_0011, 64'h7FC0_0022, 64'h7FC0_0000, 5'h0, "R3 qNaN a over qNaN b");
    send(0, 1, 0, 0, 64'h3F80_0000, 64'hFFC0_0033, 64'h7FC0_0000, 5'h0, "R3 qNaN b only");
    send(1, 1, 0, 0, 64'h7FF8_0000_0000_0002, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0000, 5'h0, "R3 R4 double sNaN b");
    send(1, 1, 0, 0, 64'hFFF0_0000_0000_00AB, 64'h4000_0000_0000_0000, 64'h7FF8_0000_0000_0000, 5'h0, "R4 double sNaN a sign kept");
    // R2 default NaN
    send(0, 1, 0, 0, 64'h3F80_0000, 64'h4000_0000, 64'h7F80_1234, 5'h0, "R2 no operand NaN single");
    send(1, 1, 0, 0, 64'h3FF0_0000_0000_0000, 64'h0, 64'hFFF0_0000_0000_0001, 5'h0, "R2 no operand NaN double");
    send(0, 1, 0, 1, 64'h7F80_0005, 64'h7FC0_0001, 64'h7FC0_0000, 5'h0, "R2 default-NaN mode single");
    send(1, 0, 0, 1, 64'h7FF0_0000_0000_0003, 64'h0, 64'h7FF8_0000_0000_0000, 5'h0, "R2 default-NaN mode double");
    // R6 ftz off: subnormal passes, no underflow
    send(0, 1, 0, 0, 64'h0000_0400, 64'h8000_0001, 64'h8000_0123, 5'h0, "R6 R7 ftz off passes subnormals");
    idle(2);
    // R6 result flush
    send(0, 1, 1, 0, 64'h3F80_0000, 64'h3F80_0000, 64'h8000_0123, 5'h0, "R6 single result flush negative");
    send(1, 1, 1, 0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h800F_0000_0000_0000, 5'h0, "R6 double result flush");
    send(0, 1, 1, 0, 64'h3F80_0000, 64'h3F80_0000, 64'h0000_0001, 5'h0, "R6 positive subnormal result");
    // R7 operand flush to positive zero
    send(0, 1, 1, 0, 64'h0000_0400, 64'h8000_0001, 64'h3F80_0000, 5'h0, "R7 both operands flushed");
    send(1, 1, 1, 0, 64'h800F_FFFF_FFFF_FFFF, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, 5'h0, "R7 double operand flushed");
    // R8 core flags merge and stick
    send(0, 1, 0, 0, 64'h3F80_0000, 64'h3F80_0000, 64'h3F80_0000, 5'b10001, "R8 core invalid inexact");
    send(0, 1, 0, 0, 64'h3F80_0000, 64'h3F80_0000, 64'h3F80_0000, 5'b00110, "R8 core dz overflow");
    send(0, 1, 0, 0, 64'h3F80_0000, 64'h3F80_0000, 64'h3F80_0000, 5'b00000, "R8 flags stay");
    idle(4);
    chk("R8 idle keeps flags", "flags", {58'h0, in_denorm, exc_flags}, {58'h0, m_idn, m_flg});
    chk("R1 idle no valid", "valid", {63'h0, out_valid}, 64'h0);
    if (exp_q.size() != 0) chk("R1 pending results", "queue", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule